// File: doc/BRIEF.md
# Angular Reference Sample Selector

This block sits in front of an angular intra-prediction interpolation filter. It assembles a one-dimensional reference line for the current block from the neighbouring pixels above or to the left. Then, for each target sample position, it returns the four neighbouring reference pixels the filter needs, the 5-bit fractional phase that picks the filter's coefficient set, and a flag that tells the filter which coefficient family to use.

A configuration pulse starts the process. The pulse carries the mode number (2..66), the signed prediction angle in 1/32-sample units, and the block size. For the next 2N+1 cycles the block copies the reference line into its own storage, one pixel per cycle. It then raises `ready`. Queries of (x, y) are accepted only while `ready` is high. Each accepted query produces a registered result one cycle later. Modes below 34 predict horizontally: the roles of x and y are swapped, so the output is the transpose of the vertical case.

Top module: `ang_ref_select`

## Requirements
- R1: After a one-cycle `cfg_start`, `ready` is low for exactly 2N+1 cycles and then high, where N = 4 << `cfg_size`. It stays high until the next `cfg_start`. Before the first configuration completes, `ready` is low.
- R2: A query (`q_valid` high) while `ready` is low is ignored: `o_valid` stays low in the following cycle.
- R3: With a non-negative angle, reference entry k (0 ≤ k ≤ 2N) is `above_px` pixel k when the mode is 34 or more, and `left_px` pixel k when the mode is below 34. Pixel k of a neighbour bus occupies bits [8k+7:8k].
- R4: With a negative angle, reference entries 0..3 are taken from the other side, in reverse: entry k is pixel 3−k of the opposite bus. Entries from 4 upward still come from the main side.
- R5: Let P = (major+1)·angle, where major is y for modes ≥ 34 and x for modes < 34. Then `o_frac` equals P mod 32, taken as the low 5 bits, and the integer offset D equals floor(P/32), an arithmetic right shift by 5.
- R6: The base index is i = D + minor + 1, where minor is the coordinate that is not major. It is clamped to the range 0..2N−1. `o_p1` is reference entry i and `o_p2` is entry i+1.
- R7: `o_p0` equals entry i−1, except at i = 0, where it repeats `o_p1`.
- R8: `o_p3` equals entry i+2, except when i+1 is the last entry (2N), where it repeats `o_p2`.
- R9: `o_gauss` is 0 for sizes 4 and 8 (`cfg_size` codes 0 and 1). It is 1 for sizes 16 and 32 (codes 2 and 3).
- R10: A query accepted at a clock edge gives `o_valid` high together with its result after that same edge, for exactly one cycle per query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | One-cycle pulse that latches the configuration and starts the fill |
| cfg_mode | input | 7 | Angular mode number, 2..66 |
| cfg_angle | input | 10 | Signed prediction angle, 1/32-sample units |
| cfg_size | input | 2 | Block size code: 0=4, 1=8, 2=16, 3=32 |
| above_px | input | 520 | Above neighbour line, 65 pixels of 8 bits, pixel 0 in the low bits |
| left_px | input | 520 | Left neighbour line, same packing |
| ready | output | 1 | Reference line filled; queries accepted |
| q_valid | input | 1 | Query strobe |
| q_x | input | 5 | Target column |
| q_y | input | 5 | Target row |
| o_valid | output | 1 | Result valid |
| o_p0 | output | 8 | Tap 0 |
| o_p1 | output | 8 | Tap 1 |
| o_p2 | output | 8 | Tap 2 |
| o_p3 | output | 8 | Tap 3 |
| o_frac | output | 5 | Fractional phase |
| o_gauss | output | 1 | Coefficient family: 1 = smoothing, 0 = cubic |

## Verification
The above and left lines carry disjoint, position-coded pixel values, so each tap shows which side and which entry it came from. Tests sweep every block size with a vertical and a horizontal mode, at positive and negative angles that have a non-zero fraction. This separates a swapped x/y, the wrong source side, or a bad opposite-side projection from correct behaviour. Whole-sample angles of ±32 drive the index to both clamp limits, which exposes missing end replication. Probes made during the fill and counted fill lengths tie `ready` to 2N+1 cycles for each size.

// File: rtl/ang_ref_pkg.sv
package ang_ref_pkg;

  typedef enum logic [1:0] {LD_IDLE, LD_FILL, LD_DONE} ld_state_e;

  // integer part of a 1/32-sample displacement (floor)
  function automatic int disp_int(input int prod);
    return prod >>> 5;
  endfunction

  // fractional phase of a 1/32-sample displacement
  function automatic logic [4:0] disp_frac(input int prod);
    return prod[4:0];
  endfunction

  // clamp a signed index into [lo, hi]
  function automatic int clamp_idx(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // size codes 2 and above (16 and 32) use the smoothing family
  function automatic logic fam_is_gauss(input int size_code);
    return size_code >= 2;
  endfunction

endpackage

// File: rtl/ang_ref_loader.sv
module ang_ref_loader
  import ang_ref_pkg::*;
#(
  parameter int PW   = 8,
  parameter int NMAX = 32,
  localparam int LEN_MAX = 2 * NMAX + 1,
  localparam int IW      = $clog2(LEN_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  vert_i,
  input  logic                  neg_i,
  input  logic [IW-1:0]         last_i,
  input  logic [LEN_MAX*PW-1:0] above_i,
  input  logic [LEN_MAX*PW-1:0] left_i,
  output logic                  ready_o,
  output logic                  vert_o,
  output logic [IW-1:0]         last_o,
  output logic                  fill_last_o,
  output logic [LEN_MAX*PW-1:0] ref_o
);

  ld_state_e       state;
  logic [IW-1:0]   cnt;
  logic [IW-1:0]   last_q;
  logic            vert_q;
  logic            neg_q;
  logic [PW-1:0]   mem     [LEN_MAX];
  logic [PW-1:0]   above_a [LEN_MAX];
  logic [PW-1:0]   left_a  [LEN_MAX];
  logic [PW-1:0]   src_px;
  logic [IW-1:0]   opp_k;

  always_comb begin
    for (int k = 0; k < LEN_MAX; k++) begin
      above_a[k] = above_i[k*PW +: PW];
      left_a[k]  = left_i[k*PW +: PW];
    end
  end

  // entries 0..3 come reversed from the opposite side when the angle is negative
  always_comb begin
    opp_k = IW'(3) - cnt;
    if (neg_q && (cnt < IW'(4)))
      src_px = vert_q ? left_a[opp_k] : above_a[opp_k];
    else
      src_px = vert_q ? above_a[cnt] : left_a[cnt];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= LD_IDLE;
      cnt    <= '0;
      last_q <= '0;
      vert_q <= 1'b0;
      neg_q  <= 1'b0;
      for (int k = 0; k < LEN_MAX; k++) mem[k] <= '0;
    end else if (start_i) begin
      state  <= LD_FILL;
      cnt    <= '0;
      last_q <= last_i;
      vert_q <= vert_i;
      neg_q  <= neg_i;
    end else if (state == LD_FILL) begin
      mem[cnt] <= src_px;
      if (cnt == last_q) state <= LD_DONE;
      else               cnt   <= cnt + IW'(1);
    end
  end

  always_comb begin
    for (int k = 0; k < LEN_MAX; k++) ref_o[k*PW +: PW] = mem[k];
  end

  assign ready_o     = (state == LD_DONE);
  assign vert_o      = vert_q;
  assign last_o      = last_q;
  assign fill_last_o = (state == LD_FILL) && (cnt == last_q);

endmodule

// File: rtl/ang_tap_locator.sv
module ang_tap_locator
  import ang_ref_pkg::*;
#(
  parameter int PW    = 8,
  parameter int NMAX  = 32,
  parameter int ANG_W = 10,
  localparam int LEN_MAX = 2 * NMAX + 1,
  localparam int IW      = $clog2(LEN_MAX + 1),
  localparam int CW      = $clog2(NMAX)
) (
  input  logic                    vert_i,
  input  logic signed [ANG_W-1:0] angle_i,
  input  logic [CW-1:0]           x_i,
  input  logic [CW-1:0]           y_i,
  input  logic [IW-1:0]           last_i,
  input  logic [LEN_MAX*PW-1:0]   ref_i,
  output logic [PW-1:0]           p0_o,
  output logic [PW-1:0]           p1_o,
  output logic [PW-1:0]           p2_o,
  output logic [PW-1:0]           p3_o,
  output logic [4:0]              frac_o,
  output logic                    at_low_o,
  output logic                    at_high_o
);

  logic [PW-1:0] r [LEN_MAX];
  logic [CW-1:0] major, minor;
  logic [IW-1:0] idx_u, idx_m1, idx_p1, idx_p2;
  int            prod, raw, idx;

  always_comb begin
    for (int k = 0; k < LEN_MAX; k++) r[k] = ref_i[k*PW +: PW];
  end

  // horizontal modes swap the coordinate roles
  assign major = vert_i ? y_i : x_i;
  assign minor = vert_i ? x_i : y_i;

  always_comb begin
    prod   = (int'(major) + 1) * int'(angle_i);
    raw    = disp_int(prod) + int'(minor) + 1;
    idx    = clamp_idx(raw, 0, int'(last_i) - 1);
    idx_u  = idx[IW-1:0];
    idx_p1 = idx_u + IW'(1);
    idx_p2 = idx_u + IW'(2);
    idx_m1 = (idx_u == '0) ? '0 : idx_u - IW'(1);
  end

  assign at_low_o  = (idx_u == '0);
  assign at_high_o = (idx_p1 == last_i);
  assign frac_o    = disp_frac(prod);
  assign p1_o      = r[idx_u];
  assign p2_o      = r[idx_p1];
  assign p0_o      = at_low_o  ? r[idx_u]  : r[idx_m1];
  assign p3_o      = at_high_o ? r[idx_p1] : r[idx_p2];

endmodule

// File: rtl/ang_ref_select.sv
module ang_ref_select
  import ang_ref_pkg::*;
#(
  parameter int PW     = 8,
  parameter int NMAX   = 32,
  parameter int ANG_W  = 10,
  parameter int MODE_W = 7,
  parameter int VERT_MIN_MODE = 34,
  localparam int LOG2N   = $clog2(NMAX),
  localparam int SZ_W    = $clog2(LOG2N - 1),
  localparam int LEN_MAX = 2 * NMAX + 1,
  localparam int IW      = $clog2(LEN_MAX + 1),
  localparam int CW      = LOG2N
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_start,
  input  logic [MODE_W-1:0]       cfg_mode,
  input  logic signed [ANG_W-1:0] cfg_angle,
  input  logic [SZ_W-1:0]         cfg_size,
  input  logic [LEN_MAX*PW-1:0]   above_px,
  input  logic [LEN_MAX*PW-1:0]   left_px,
  output logic                    ready,
  input  logic                    q_valid,
  input  logic [CW-1:0]           q_x,
  input  logic [CW-1:0]           q_y,
  output logic                    o_valid,
  output logic [PW-1:0]           o_p0,
  output logic [PW-1:0]           o_p1,
  output logic [PW-1:0]           o_p2,
  output logic [PW-1:0]           o_p3,
  output logic [4:0]              o_frac,
  output logic                    o_gauss
);

  logic                    cfg_vert;
  logic [IW-1:0]           cfg_last;
  logic                    ld_vert;
  logic [IW-1:0]           ld_last;
  logic                    ld_fill_last;
  logic [LEN_MAX*PW-1:0]   ref_line;
  logic signed [ANG_W-1:0] angle_q;
  logic                    gauss_q;
  logic                    q_take;
  logic [PW-1:0]           loc_p0, loc_p1, loc_p2, loc_p3;
  logic [4:0]              loc_frac;
  logic                    loc_at_low, loc_at_high;

  assign cfg_vert = (int'(cfg_mode) >= VERT_MIN_MODE);
  assign cfg_last = IW'(32'd8 << cfg_size);   // 2N with N = 4 << size
  assign q_take   = q_valid && ready;

  ang_ref_loader #(.PW(PW), .NMAX(NMAX)) u_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (cfg_start),
    .vert_i      (cfg_vert),
    .neg_i       (cfg_angle < 0),
    .last_i      (cfg_last),
    .above_i     (above_px),
    .left_i      (left_px),
    .ready_o     (ready),
    .vert_o      (ld_vert),
    .last_o      (ld_last),
    .fill_last_o (ld_fill_last),
    .ref_o       (ref_line)
  );

  ang_tap_locator #(.PW(PW), .NMAX(NMAX), .ANG_W(ANG_W)) u_locator (
    .vert_i    (ld_vert),
    .angle_i   (angle_q),
    .x_i       (q_x),
    .y_i       (q_y),
    .last_i    (ld_last),
    .ref_i     (ref_line),
    .p0_o      (loc_p0),
    .p1_o      (loc_p1),
    .p2_o      (loc_p2),
    .p3_o      (loc_p3),
    .frac_o    (loc_frac),
    .at_low_o  (loc_at_low),
    .at_high_o (loc_at_high)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angle_q <= '0;
      gauss_q <= 1'b0;
    end else if (cfg_start) begin
      angle_q <= cfg_angle;
      gauss_q <= fam_is_gauss(int'(cfg_size));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_p0    <= '0;
      o_p1    <= '0;
      o_p2    <= '0;
      o_p3    <= '0;
      o_frac  <= '0;
      o_gauss <= 1'b0;
    end else begin
      o_valid <= q_take;
      if (q_take) begin
        o_p0    <= loc_p0;
        o_p1    <= loc_p1;
        o_p2    <= loc_p2;
        o_p3    <= loc_p3;
        o_frac  <= loc_frac;
        o_gauss <= gauss_q;
      end
    end
  end

endmodule

// File: rtl/ang_ref_select_chk.sv
module ang_ref_select_chk #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_start,
  input logic          ready,
  input logic          q_valid,
  input logic          o_valid,
  input logic [PW-1:0] o_p0,
  input logic [PW-1:0] o_p1,
  input logic [PW-1:0] o_p2,
  input logic [PW-1:0] o_p3,
  input logic          loc_at_low,
  input logic          loc_at_high,
  input logic          ld_fill_last
);

  assert_start_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |=> !ready);

  assert_ready_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !cfg_start) |=> ready);

  assert_fill_end_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fill_last && !cfg_start) |=> ready);

  assert_valid_needs_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> $past(q_valid && ready));

  assert_low_edge_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && $past(loc_at_low)) |-> (o_p0 == o_p1));

  assert_high_edge_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && $past(loc_at_high)) |-> (o_p3 == o_p2));

endmodule

bind ang_ref_select ang_ref_select_chk #(.PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_start    (cfg_start),
  .ready        (ready),
  .q_valid      (q_valid),
  .o_valid      (o_valid),
  .o_p0         (o_p0),
  .o_p1         (o_p1),
  .o_p2         (o_p2),
  .o_p3         (o_p3),
  .loc_at_low   (loc_at_low),
  .loc_at_high  (loc_at_high),
  .ld_fill_last (ld_fill_last)
);

// File: tb/ang_ref_select_test.sv
module ang_ref_select_test;

  localparam int PW = 8;
  localparam int NMAX = 32;
  localparam int LEN_MAX = 2 * NMAX + 1;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  cfg_start = 1'b0;
  logic [6:0]            cfg_mode = '0;
  logic signed [9:0]     cfg_angle = '0;
  logic [1:0]            cfg_size = '0;
  logic [LEN_MAX*PW-1:0] above_px, left_px;
  logic                  ready;
  logic                  q_valid = 1'b0;
  logic [4:0]            q_x = '0, q_y = '0;
  logic                  o_valid;
  logic [PW-1:0]         o_p0, o_p1, o_p2, o_p3;
  logic [4:0]            o_frac;
  logic                  o_gauss;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model configuration
  bit cur_vert, cur_neg;
  int cur_n, cur_ang;

  always #5 clk = ~clk;

  ang_ref_select uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_angle(cfg_angle), .cfg_size(cfg_size), .above_px(above_px), .left_px(left_px),
    .ready(ready), .q_valid(q_valid), .q_x(q_x), .q_y(q_y), .o_valid(o_valid),
    .o_p0(o_p0), .o_p1(o_p1), .o_p2(o_p2), .o_p3(o_p3), .o_frac(o_frac), .o_gauss(o_gauss)
  );

  function automatic int above_val(int k); return k + 1;   endfunction
  function automatic int left_val(int k);  return 100 + k; endfunction

  function automatic int ref_val(int k);
    if (cur_neg && k < 4) return cur_vert ? left_val(3 - k) : above_val(3 - k);
    return cur_vert ? above_val(k) : left_val(k);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R1: configure and measure the fill length
  task automatic do_load(input int mode, input int ang, input int szc);
    int lows;
    @(negedge clk);
    cfg_mode = 7'(mode); cfg_angle = 10'(ang); cfg_size = 2'(szc); cfg_start = 1'b1;
    cur_vert = (mode >= 34); cur_neg = (ang < 0); cur_n = 4 << szc; cur_ang = ang;
    @(negedge clk);
    cfg_start = 1'b0;
    lows = 0;
    while (!ready && lows < 200) begin
      lows++;
      @(negedge clk);
    end
    check(lows == 2 * cur_n + 1, "R1 fill length", lows, 2 * cur_n + 1);
  endtask

  // R5..R10: one query against the model
  task automatic query(input int x, input int y);
    int maj, mn, prod, fl, fr, idx, e0, e1, e2, e3;
    maj = cur_vert ? y : x;
    mn  = cur_vert ? x : y;
    prod = (maj + 1) * cur_ang;
    fl = (prod >= 0) ? prod / 32 : -((-prod + 31) / 32);
    fr = prod - fl * 32;
    idx = fl + mn + 1;
    if (idx < 0) idx = 0;
    if (idx > 2 * cur_n - 1) idx = 2 * cur_n - 1;
    e1 = ref_val(idx);
    e2 = ref_val(idx + 1);
    e0 = (idx == 0) ? e1 : ref_val(idx - 1);
    e3 = (idx + 1 == 2 * cur_n) ? e2 : ref_val(idx + 2);
    @(negedge clk);
    q_valid = 1'b1; q_x = 5'(x); q_y = 5'(y);
    @(negedge clk);
    q_valid = 1'b0;
    check(o_valid == 1'b1, "R10 valid", int'(o_valid), 1);
    check(o_frac == 5'(fr), "R5 frac", int'(o_frac), fr);
    check(o_p1 == 8'(e1) && o_p2 == 8'(e2), "R6 p1p2",
          int'(o_p1) * 256 + int'(o_p2), e1 * 256 + e2);
    check(o_p0 == 8'(e0), "R7 p0", int'(o_p0), e0);
    check(o_p3 == 8'(e3), "R8 p3", int'(o_p3), e3);
    check(o_gauss == (cur_n >= 16), "R9 family", int'(o_gauss), int'(cur_n >= 16));
    @(negedge clk);
    check(o_valid == 1'b0, "R10 single pulse", int'(o_valid), 0);
  endtask

  task automatic t_reset;
    check(ready == 1'b0, "R1 reset ready", int'(ready), 0);
    check(o_valid == 1'b0, "R10 reset valid", int'(o_valid), 0);
  endtask

  task automatic t_sides;
    // R3: vertical, whole-sample angle: x=0,y=0 -> index 2
    do_load(50, 32, 0);
    query(0, 0);
    check(o_p1 == 8'(above_val(2)), "R3 above side", int'(o_p1), above_val(2));
    do_load(18, 32, 0);
    query(0, 0);
    check(o_p1 == 8'(left_val(2)), "R3 left side", int'(o_p1), left_val(2));
    // R4: negative angle, index 1 spans the projected entries
    do_load(40, -32, 1);
    query(1, 0);
    check(o_p0 == 8'(left_val(3)) && o_p3 == 8'(left_val(0)), "R4 projected",
          int'(o_p0) * 256 + int'(o_p3), left_val(3) * 256 + left_val(0));
    do_load(28, -32, 1);
    query(0, 1);
    check(o_p2 == 8'(above_val(1)), "R4 projected horiz", int'(o_p2), above_val(1));
  endtask

  task automatic t_not_ready;
    @(negedge clk);
    cfg_mode = 7'd50; cfg_angle = 10'sd13; cfg_size = 2'd2; cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0; q_valid = 1'b1; q_x = 5'd1; q_y = 5'd1;
    @(negedge clk);
    q_valid = 1'b0;
    check(o_valid == 1'b0, "R2 query ignored while filling", int'(o_valid), 0);
    check(ready == 1'b0, "R1 still filling", int'(ready), 0);
    while (!ready) @(negedge clk);
  endtask

  task automatic t_sweep;
    int modes[4] = '{50, 18, 40, 28};
    int angs[4]  = '{13, 13, -13, -21};
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 4; m++) begin
        do_load(modes[m], angs[m], s);
        query(0, 0);
        query((4 << s) - 1, (4 << s) - 1);
        query((4 << s) / 2, 1);
        query(1, (4 << s) / 2);
      end
    end
  endtask

  task automatic t_edges;
    for (int s = 0; s < 4; s++) begin
      do_load(66, 32, s);                       // high clamp, R8
      query((4 << s) - 1, (4 << s) - 1);
      do_load(2, 32, s);
      query((4 << s) - 1, (4 << s) - 1);
      do_load(34, -32, s);                      // low clamp, R7
      query(0, (4 << s) - 1);
      query(0, 0);
    end
  endtask

  initial begin
    for (int k = 0; k < LEN_MAX; k++) begin
      above_px[k*PW +: PW] = 8'(above_val(k));
      left_px[k*PW +: PW]  = 8'(left_val(k));
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sides();
    t_not_ready();
    t_sweep();
    t_edges();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule